// File: doc/BRIEF.md
# Bus Contention Fault Monitor

This block guards the transmit path of a single-wire bus transceiver. While the chip is selected, it compares the transmit data the controller sends with the level it reads back from the bus. A disagreement counts as contention only after it has been seen on several sample ticks in a row. The sample ticks come from a divided clock, and the required run length is a parameter. Together these absorb the loop delay of the bus. The contention result is merged with any number of internal fault flags, such as over-temperature or short-circuit. Any active fault pulls the shared open-drain fault/transmit-enable line low.

The same line is read back as the transmit-enable input. The effective transmit enable handed to the mode controller is high only when the line reads high and no fault of any kind is active. An external driver forcing the line high therefore cannot re-enable a faulted transmitter. While chip select is low, the line carries a latched wake-source indication instead of fault status.

Top module: `busFaultMonitor`

## Requirements
- R1: After reset the debounce run is zero, contention is clear and the wake latch holds 0. With chip select high and no internal fault, `faultPullDown` is 0 and `txEnable` equals `lineLevel`.
- R2: Samples are taken on one clock in every `TICK_DIV` clocks, counted from reset release. While chip select is high, a sample where `txData` differs from `busLevel` extends the mismatch run. When the run reaches `DEBOUNCE`, contention is set from the next clock. Contention drives `faultPullDown` high and `txEnable` low.
- R3: A sample where `txData` equals `busLevel` clears both the run and contention from the next clock.
- R4: Input values between sample ticks have no effect. A mismatch that is never present on a tick never raises contention.
- R5: Chip select low clears the run and contention at every clock, and mismatches are then ignored. If chip select falls on the very tick that would complete the run, the clear wins.
- R6: While chip select is high, any bit set in `intFault` drives `faultPullDown` high in the same cycle, without any delay.
- R7: `txEnable` is 1 only when `lineLevel` is 1, `intFault` is all zero and contention is clear. A high `lineLevel` never overrides a fault.
- R8: Once all faults have cleared and `lineLevel` is high, `txEnable` returns to 1 with no further delay.
- R9: On a clock where chip select is low and `wakeStrobe` is 1, `wakeLocal` captures `wakeIsLocal` (1 = local wake, 0 = bus wake). It holds that value until the next such clock. Strobes while chip select is high are ignored.
- R10: While chip select is low, `faultPullDown` equals the latched `wakeLocal` value. Internal faults and mismatches do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Chip select from the controller |
| txData | input | 1 | Transmit data (0 = dominant) |
| busLevel | input | 1 | Received bus level (0 = dominant) |
| intFault | input | NUM_FAULT | Internal fault flags, 1 = fault |
| lineLevel | input | 1 | Read-back of the fault/transmit-enable line |
| wakeStrobe | input | 1 | One-cycle wake event |
| wakeIsLocal | input | 1 | Source of the wake event, 1 = local |
| faultPullDown | output | 1 | Enables the open-drain pull-down on the line |
| txEnable | output | 1 | Effective transmit enable for the mode controller |
| wakeLocal | output | 1 | Latched wake source |

## Verification
Two functions can land in the same cycle: the sample tick that completes the debounce run, and a chip-select fall that must clear it. The bench waits until its model shows a run of `DEBOUNCE`-1 with a tick on the next edge. It then drops chip select at that moment and also raises a wake strobe. The bench then expects no contention, and expects the wake latch to load. A second case is an internal fault that appears in the same cycle as contention rises. This case is judged through `txEnable` and through `faultPullDown` staying high until both causes are gone.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic sampleNow;  // sample tick this clock
    logic clearRun;   // chip select low: drop run and contention
  } fmonStrobe_t;
endpackage

// File: rtl/fmon_ctrl.sv
module fmon_ctrl
  import fmon_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSel,
  input  logic        wakeStrobe,
  input  logic        wakeIsLocal,
  output fmonStrobe_t strobe,
  output logic        wakeLatched
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tickNow;

  assign tickNow = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tickNow) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // wake source latch, loaded only while deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeLatched <= 1'b0;
    end else if (!chipSel && wakeStrobe) begin
      wakeLatched <= wakeIsLocal;
    end
  end

  always_comb begin
    strobe.sampleNow = tickNow;
    strobe.clearRun  = !chipSel;
  end
endmodule

// File: rtl/fmon_dp.sv
module fmon_dp
  import fmon_pkg::*;
#(
  parameter int DEBOUNCE  = 3,
  parameter int NUM_FAULT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fmonStrobe_t          strobe,
  input  logic                 chipSel,
  input  logic                 txData,
  input  logic                 busLevel,
  input  logic [NUM_FAULT-1:0] intFault,
  input  logic                 lineLevel,
  input  logic                 wakeLatched,
  output logic                 faultPullDown,
  output logic                 txEnable
);
  localparam int CNT_W = $clog2(DEBOUNCE + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEBOUNCE);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;
  logic             contention;
  logic             anyFault;

  assign runNext = (runCnt == CNT_TOP) ? CNT_TOP : runCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt     <= '0;
      contention <= 1'b0;
    end else if (strobe.clearRun) begin
      runCnt     <= '0;
      contention <= 1'b0;
    end else if (strobe.sampleNow) begin
      if (txData != busLevel) begin
        runCnt     <= runNext;
        contention <= (runNext == CNT_TOP);
      end else begin
        runCnt     <= '0;
        contention <= 1'b0;
      end
    end
  end

  assign anyFault      = contention | (|intFault);
  assign faultPullDown = chipSel ? anyFault : wakeLatched;
  assign txEnable      = lineLevel & ~anyFault;
endmodule

// File: rtl/busFaultMonitor.sv
module busFaultMonitor
  import fmon_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int DEBOUNCE  = 3,
  parameter int NUM_FAULT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSel,
  input  logic                 txData,
  input  logic                 busLevel,
  input  logic [NUM_FAULT-1:0] intFault,
  input  logic                 lineLevel,
  input  logic                 wakeStrobe,
  input  logic                 wakeIsLocal,
  output logic                 faultPullDown,
  output logic                 txEnable,
  output logic                 wakeLocal
);
  fmonStrobe_t strobe;
  logic        wakeLatched;

  fmon_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel),
    .wakeStrobe(wakeStrobe), .wakeIsLocal(wakeIsLocal),
    .strobe(strobe), .wakeLatched(wakeLatched)
  );

  fmon_dp #(.DEBOUNCE(DEBOUNCE), .NUM_FAULT(NUM_FAULT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chipSel(chipSel),
    .txData(txData), .busLevel(busLevel), .intFault(intFault),
    .lineLevel(lineLevel), .wakeLatched(wakeLatched),
    .faultPullDown(faultPullDown), .txEnable(txEnable)
  );

  assign wakeLocal = wakeLatched;
endmodule

// File: rtl/fmon_checker.sv
module fmon_checker #(
  parameter int NUM_FAULT = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chipSel,
  input logic                 txData,
  input logic                 busLevel,
  input logic [NUM_FAULT-1:0] intFault,
  input logic                 lineLevel,
  input logic                 wakeStrobe,
  input logic                 faultPullDown,
  input logic                 txEnable,
  input logic                 wakeLocal
);
  AST_FAULT_PULLS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && intFault != '0) |-> faultPullDown); // R6

  AST_FAULT_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rstN)
    (intFault != '0) |-> !txEnable); // R7

  AST_TX_REENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && lineLevel && intFault == '0 && !faultPullDown) |-> txEnable); // R8

  AST_RISE_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && $past(chipSel) && $rose(faultPullDown) && intFault == '0 && $past(intFault) == '0)
      |-> $past(txData != busLevel)); // R2

  AST_SELECT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !$past(chipSel) && intFault == '0) |-> !faultPullDown); // R5

  AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chipSel) || !$past(wakeStrobe)) |-> $stable(wakeLocal)); // R9
endmodule

bind busFaultMonitor fmon_checker #(.NUM_FAULT(NUM_FAULT)) u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .txData(txData),
  .busLevel(busLevel), .intFault(intFault), .lineLevel(lineLevel),
  .wakeStrobe(wakeStrobe), .faultPullDown(faultPullDown),
  .txEnable(txEnable), .wakeLocal(wakeLocal)
);

// File: tb/tb_busFaultMonitor.sv
module tb_busFaultMonitor;
  localparam int CLK_PERIOD = 10;
  localparam int TD  = 4;
  localparam int DEB = 3;
  localparam int NF  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b1, txData = 1'b1, busLevel = 1'b1;
  logic [NF-1:0] intFault = '0;
  logic lineLevel = 1'b1, wakeStrobe = 1'b0, wakeIsLocal = 1'b0;
  logic faultPullDown, txEnable, wakeLocal;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // reference model state
  int  mDiv = 0;
  int  mRun = 0;
  bit  mCont = 0;
  bit  mWake = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busFaultMonitor #(.TICK_DIV(TD), .DEBOUNCE(DEB), .NUM_FAULT(NF)) dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .txData(txData),
    .busLevel(busLevel), .intFault(intFault), .lineLevel(lineLevel),
    .wakeStrobe(wakeStrobe), .wakeIsLocal(wakeIsLocal),
    .faultPullDown(faultPullDown), .txEnable(txEnable), .wakeLocal(wakeLocal)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mRun = 0; mCont = 0; mWake = 0;
    end else begin
      bit tick;
      tick = (mDiv == TD - 1);
      mDiv = tick ? 0 : mDiv + 1;
      if (!chipSel) begin
        mRun = 0; mCont = 0;
        if (wakeStrobe) mWake = wakeIsLocal;
      end else if (tick) begin
        if (txData != busLevel) begin
          if (mRun < DEB) mRun++;
          mCont = (mRun == DEB);
        end else begin
          mRun = 0; mCont = 0;
        end
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      bit anyF;
      @(negedge clk);
      anyF = mCont || (intFault != '0);
      chk("faultPullDown", faultPullDown, chipSel ? anyF : mWake);
      chk("txEnable", txEnable, lineLevel && !anyF);
      chk("wakeLocal", wakeLocal, mWake);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; step(6);
    chk("R1 idle pull-down", faultPullDown, 1'b0);

    curReq = "R2"; txData = 1'b0; step(20);
    chk("R2 contention raised", faultPullDown, 1'b1);
    chk("R2 tx blocked", txEnable, 1'b0);

    curReq = "R3"; txData = 1'b1; step(8);
    chk("R3 cleared", faultPullDown, 1'b0);
    for (int k = 0; k < 3; k++) begin
      busLevel = 1'b0; step(2 * TD);
      busLevel = 1'b1; step(TD);
    end

    curReq = "R4";
    for (int k = 0; k < 40; k++) begin
      txData = (mDiv == TD - 1) ? 1'b1 : 1'b0;
      step(1);
    end
    txData = 1'b1; step(2);
    chk("R4 off-tick mismatch ignored", faultPullDown, 1'b0);

    curReq = "R5"; chipSel = 1'b0; txData = 1'b0; step(30);
    chipSel = 1'b1; step(1);
    while (!(mRun == DEB - 1 && mDiv == TD - 1)) step(1);
    chipSel = 1'b0; wakeStrobe = 1'b1; wakeIsLocal = 1'b1; step(1);
    wakeStrobe = 1'b0; chipSel = 1'b1; step(1);
    chk("R5 clear beats completing tick", faultPullDown, 1'b0);
    chk("R9 wake taken on deselect", wakeLocal, 1'b1);
    txData = 1'b1; step(4);

    curReq = "R6"; intFault = 2'b01; step(3);
    intFault = 2'b10; step(3);
    intFault = 2'b10; txData = 1'b0; step(16);

    curReq = "R7"; lineLevel = 1'b1; step(4);
    chk("R7 forced line no override", txEnable, 1'b0);
    intFault = '0; txData = 1'b1; lineLevel = 1'b0; step(TD + 2);
    chk("R7 low line", txEnable, 1'b0);

    curReq = "R8"; lineLevel = 1'b1; step(3);
    chk("R8 re-enabled", txEnable, 1'b1);

    curReq = "R9"; chipSel = 1'b0; wakeStrobe = 1'b1; wakeIsLocal = 1'b0; step(1);
    wakeStrobe = 1'b0; wakeIsLocal = 1'b1; step(5);
    chk("R9 bus wake held", wakeLocal, 1'b0);
    chipSel = 1'b1; wakeStrobe = 1'b1; step(2);
    wakeStrobe = 1'b0; step(2);
    chk("R9 strobe while selected ignored", wakeLocal, 1'b0);
    chipSel = 1'b0; wakeStrobe = 1'b1; wakeIsLocal = 1'b1; step(1);
    wakeStrobe = 1'b0; step(2);

    curReq = "R10"; intFault = 2'b11; txData = 1'b0; step(10);
    wakeStrobe = 1'b1; wakeIsLocal = 1'b0; step(1);
    wakeStrobe = 1'b0; step(6);
    chk("R10 line shows wake only", faultPullDown, 1'b0);
    intFault = '0; txData = 1'b1; chipSel = 1'b1; step(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule